// File: doc/BRIEF.md
# One-of-Four Symbol Downlink Encoder

This block drives the carrier enable for a low-frequency transponder downlink. Commands are sent by switching the field off briefly between carrier-on pulses. The length of each on pulse carries two bits. An upstream packer presents 2-bit symbols on a valid/ready stream and marks the final symbol of a command with a last flag. The encoder turns each symbol into one of four on-times and puts a fixed off gap after each one.

The field is on while the block is idle, so the transponder stays powered. The first accepted symbol opens a frame. The encoder first drops the field for a long lead-in gap. It then sends a reference pulse of value 00, which the transponder uses to calibrate the other three widths. After that it plays the symbols in the order they are accepted. When the gap after the last symbol ends, the field comes back on and the block is idle again. All durations are counted in periods of a 1 MHz tick strobe. The clock can run at any faster rate.

Top module: `dl_1of4_enc`

## Requirements
- R1: After reset the block is idle: field_on_o is 1 and sym_ready_o is 1.
- R2: A handshake (sym_valid_i and sym_ready_o both 1 at a clock edge) taken while idle opens a frame. The field is then off for 248 ticks (31 units of 8 ticks).
- R3: After the lead-in gap comes a reference pulse of 144 ticks of field on. Its length does not depend on the value of the first symbol.
- R4: Each accepted symbol gives an on pulse of (18 + 16*v)*8 ticks, where v is the unsigned value of sym_data_i. Bit 1 of sym_data_i is the bit sent earlier. So 00, 01, 10 and 11 give 144, 272, 400 and 528 ticks.
- R5: Every pulse, the reference included, is followed by 160 ticks of field off.
- R6: The symbol value and last flag are captured only on a handshake. sym_ready_o is 0 from the handshake until the gap after that symbol expires. Changes on sym_data_i or sym_last_i outside a handshake have no effect on the pulse being sent.
- R7: When the gap after a symbol flagged last expires, the field turns on and the block returns to idle with sym_ready_o at 1.
- R8: If the gap after a symbol not flagged last expires with no symbol offered, the field stays off and sym_ready_o stays 1 until a symbol is accepted. That symbol's pulse then starts immediately.
- R9: Time advances only on edges where tick_i is 1. With tick_i at 0 and no handshake, field_on_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per microsecond |
| sym_valid_i | input | 1 | A symbol is offered |
| sym_data_i | input | 2 | Symbol value; bit 1 is sent first |
| sym_last_i | input | 1 | The offered symbol ends the command |
| sym_ready_o | output | 1 | The encoder takes the offered symbol at this edge |
| field_on_o | output | 1 | Carrier enable |

## Verification
The assertions assume that tick_i is sampled on the same clock as the block and that an upstream source moves sym_valid_i, sym_data_i and sym_last_i only between edges. They make no assumption that data is held stable while valid is low. The stimulus changes every input on the falling edge. It deliberately scrambles sym_data_i whenever valid is low and the encoder is busy. It offers the next symbol early in some frames and late in others, so both back-to-back gaps and starved gaps occur. It also stops the tick strobe in the middle of a pulse.

// File: rtl/dl_1of4_pkg.sv
package dl_1of4_pkg;

  typedef logic [1:0] dl_sym_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_OFF,
    ST_REF_ON,
    ST_REF_OFF,
    ST_SYM_ON,
    ST_SYM_OFF,
    ST_STARVE
  } dl_state_e;

  // on-time in ticks for a symbol value
  function automatic int unsigned on_ticks(dl_sym_t s, int unsigned base_u,
                                           int unsigned step_u, int unsigned unit);
    return (base_u + step_u * {30'd0, s}) * unit;
  endfunction

endpackage

// File: rtl/dl_tick_timer.sv
module dl_tick_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // R9: count frozen between ticks
  a_r9_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dl_sym_hold.sv
module dl_sym_hold
  import dl_1of4_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    capture_i,
  input  dl_sym_t sym_i,
  input  logic    last_i,
  output dl_sym_t sym_o,
  output logic    last_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o  <= '0;
      last_o <= 1'b0;
    end else if (capture_i) begin
      sym_o  <= sym_i;
      last_o <= last_i;
    end
  end

  // R6: held symbol moves only on capture
  a_r6_hold_on_capture_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> ($stable(sym_o) && $stable(last_o)));

endmodule

// File: rtl/dl_seq.sv
module dl_seq
  import dl_1of4_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned LEAD_TICKS = 248,
  parameter int unsigned GAP_TICKS  = 160,
  parameter int unsigned UNIT_TICKS = 8,
  parameter int unsigned BASE_UNITS = 18,
  parameter int unsigned STEP_UNITS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  input  logic             valid_i,
  input  dl_sym_t          sym_i,
  input  dl_sym_t          held_sym_i,
  input  logic             held_last_i,
  output logic             ready_o,
  output logic             field_on_o,
  output logic             capture_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output dl_state_e        state_o
);

  localparam logic [CNT_W-1:0] LEAD_LV = CNT_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_LV  = CNT_W'(GAP_TICKS - 1);
  localparam logic [CNT_W-1:0] REF_LV  = CNT_W'(BASE_UNITS * UNIT_TICKS - 1);

  function automatic logic [CNT_W-1:0] pulse_lv(dl_sym_t s);
    return CNT_W'(on_ticks(s, BASE_UNITS, STEP_UNITS, UNIT_TICKS) - 1);
  endfunction

  dl_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    ready_o    = 1'b0;
    field_on_o = 1'b1;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (valid_i) begin
          state_d    = ST_LEAD_OFF;
          load_o     = 1'b1;
          load_val_o = LEAD_LV;
        end
      end
      ST_LEAD_OFF: begin
        field_on_o = 1'b0;
        if (expire_i) begin
          state_d    = ST_REF_ON;
          load_o     = 1'b1;
          load_val_o = REF_LV;
        end
      end
      ST_REF_ON: begin
        if (expire_i) begin
          state_d    = ST_REF_OFF;
          load_o     = 1'b1;
          load_val_o = GAP_LV;
        end
      end
      ST_REF_OFF: begin
        field_on_o = 1'b0;
        if (expire_i) begin
          state_d    = ST_SYM_ON;
          load_o     = 1'b1;
          load_val_o = pulse_lv(held_sym_i);
        end
      end
      ST_SYM_ON: begin
        if (expire_i) begin
          state_d    = ST_SYM_OFF;
          load_o     = 1'b1;
          load_val_o = GAP_LV;
        end
      end
      ST_SYM_OFF: begin
        field_on_o = 1'b0;
        if (expire_i) begin
          if (held_last_i) begin
            state_d = ST_IDLE;
          end else begin
            // gap ends this edge: accept back-to-back without a bubble
            ready_o = 1'b1;
            if (valid_i) begin
              state_d    = ST_SYM_ON;
              load_o     = 1'b1;
              load_val_o = pulse_lv(sym_i);
            end else begin
              state_d = ST_STARVE;
            end
          end
        end
      end
      ST_STARVE: begin
        field_on_o = 1'b0;
        ready_o    = 1'b1;
        if (valid_i) begin
          state_d    = ST_SYM_ON;
          load_o     = 1'b1;
          load_val_o = pulse_lv(sym_i);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign capture_o = ready_o && valid_i;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R3: reference pulse follows the lead-in gap
  a_r3_ref_after_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEAD_OFF && expire_i) |=> (state_q == ST_REF_ON));

  // R5: every pulse ends in an off gap
  a_r5_gap_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SYM_ON || state_q == ST_REF_ON) && expire_i) |=> !field_on_o);

  // R7: last symbol returns to idle
  a_r7_last_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYM_OFF && expire_i && held_last_i) |=> (state_q == ST_IDLE && field_on_o));

  // R8: starved encoder keeps waiting with field off
  a_r8_starve_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STARVE && !valid_i) |=> (state_q == ST_STARVE && !field_on_o && ready_o));

endmodule

// File: rtl/dl_1of4_enc.sv
module dl_1of4_enc
  import dl_1of4_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 8,
  parameter int unsigned LEAD_UNITS = 31,
  parameter int unsigned GAP_UNITS  = 20,
  parameter int unsigned BASE_UNITS = 18,
  parameter int unsigned STEP_UNITS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_data_i,
  input  logic       sym_last_i,
  output logic       sym_ready_o,
  output logic       field_on_o
);

  localparam int unsigned LEAD_TICKS = LEAD_UNITS * UNIT_TICKS;
  localparam int unsigned GAP_TICKS  = GAP_UNITS * UNIT_TICKS;
  localparam int unsigned TOP_TICKS  = (BASE_UNITS + 3 * STEP_UNITS) * UNIT_TICKS;
  localparam int unsigned MAX_A      = (LEAD_TICKS > GAP_TICKS) ? LEAD_TICKS : GAP_TICKS;
  localparam int unsigned MAX_TICKS  = (MAX_A > TOP_TICKS) ? MAX_A : TOP_TICKS;
  localparam int unsigned CNT_W      = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

  logic             expire, capture, load;
  logic [CNT_W-1:0] load_val;
  dl_sym_t          held_sym;
  logic             held_last;
  dl_state_e        state;

  dl_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  dl_sym_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .sym_i     (sym_data_i),
    .last_i    (sym_last_i),
    .sym_o     (held_sym),
    .last_o    (held_last)
  );

  dl_seq #(
    .CNT_W      (CNT_W),
    .LEAD_TICKS (LEAD_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .UNIT_TICKS (UNIT_TICKS),
    .BASE_UNITS (BASE_UNITS),
    .STEP_UNITS (STEP_UNITS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .expire_i    (expire),
    .valid_i     (sym_valid_i),
    .sym_i       (sym_data_i),
    .held_sym_i  (held_sym),
    .held_last_i (held_last),
    .ready_o     (sym_ready_o),
    .field_on_o  (field_on_o),
    .capture_o   (capture),
    .load_o      (load),
    .load_val_o  (load_val),
    .state_o     (state)
  );

  // R9: no tick and no handshake leaves the field alone
  a_r9_field_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(sym_valid_i && sym_ready_o)) |=> $stable(field_on_o));

  // R6: symbol under transmission does not change mid-pulse
  a_r6_pulse_value_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SYM_ON && $past(state) == ST_SYM_ON) |-> $stable(held_sym));

  // R6: not ready while a pulse is on inside a frame
  a_r6_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SYM_ON || state == ST_REF_ON || state == ST_LEAD_OFF) |-> !sym_ready_o);

endmodule

// File: tb/dl_1of4_enc_bench.sv
module dl_1of4_enc_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       valid = 1'b0;
  logic       last = 1'b0;
  logic [1:0] data = 2'b00;
  logic       ready, field;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  tick_en = 1'b1;
  int  tick_div = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  dl_1of4_enc u_dl_1of4_enc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .sym_valid_i (valid),
    .sym_data_i  (data),
    .sym_last_i  (last),
    .sym_ready_o (ready),
    .field_on_o  (field)
  );

  // tick every second clock unless stalled
  initial forever begin
    @(negedge clk);
    tick_div++;
    tick = tick_en && (tick_div % 2 == 0);
  end

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 lead gap, 2 ref on, 3 ref gap, 4 sym on, 5 sym gap, 6 starved
  int m_phase = 0, m_left = 0, m_sym = 0;
  bit m_last = 1'b0;
  bit hs;

  function automatic int on_t(int s);
    return (18 + 16 * s) * 8;
  endfunction

  function automatic bit exp_ready();
    return (m_phase == 0) || (m_phase == 6) ||
           (m_phase == 5 && tick && m_left == 1 && !m_last);
  endfunction

  function automatic bit exp_field();
    return (m_phase == 0) || (m_phase == 2) || (m_phase == 4);
  endfunction

  function automatic string tag(int p);
    case (p)
      0: return "R1 R7";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R4 R6";
      5: return "R5";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_sym = 0; m_last = 0;
    end else begin
      hs = valid && exp_ready();
      case (m_phase)
        0: if (hs) begin m_phase = 1; m_left = 248; m_sym = data; m_last = last; end
        1, 2, 3, 4: if (tick) begin
          m_left--;
          if (m_left == 0) begin
            case (m_phase)
              1: begin m_phase = 2; m_left = 144; end
              2: begin m_phase = 3; m_left = 160; end
              3: begin m_phase = 4; m_left = on_t(m_sym); end
              default: begin m_phase = 5; m_left = 160; end
            endcase
          end
        end
        5: if (tick) begin
          m_left--;
          if (m_left == 0) begin
            if (m_last) m_phase = 0;
            else if (hs) begin m_phase = 4; m_left = on_t(data); m_sym = data; m_last = last; end
            else m_phase = 6;
          end
        end
        default: if (hs) begin m_phase = 4; m_left = on_t(data); m_sym = data; m_last = last; end
      endcase
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_tests++;
      if (field !== exp_field() || ready !== exp_ready()) begin
        n_fail++;
        $display("FAIL %s field_on=%b exp=%b ready=%b exp=%b t=%0t",
                 tag(m_phase), field, exp_field(), ready, exp_ready(), $time);
      end
    end
  end

  // segment width measurement, in ticks, from the output alone
  int seg_ticks = 0;
  bit prev_f = 1'b1;
  int seg_q[$];

  always @(posedge clk) if (tick) seg_ticks++;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (field !== prev_f) begin
        seg_q.push_back(seg_ticks);
        seg_ticks = 0;
      end
      prev_f = field;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_sym(input logic [1:0] d, input bit l, input bit starve);
    if (starve) begin
      while (m_phase != 6) @(negedge clk);
      repeat (37) @(negedge clk);
      #1;
      chk(field == 1'b0 && ready == 1'b1, "R8 starved gap", {field, ready}, 2'b01);
    end
    @(negedge clk);
    valid = 1'b1; data = d; last = l;
    forever begin
      #1;
      if (ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    valid = 1'b0; data = ~d; last = ~l;
  endtask

  task automatic wait_idle();
    while (m_phase != 0) begin
      @(negedge clk);
      data = 2'($urandom);
      last = 1'($urandom);
    end
    repeat (20) @(negedge clk);
    #1;
    chk(field == 1'b1 && ready == 1'b1, "R7 back to idle", {field, ready}, 2'b11);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(field == 1'b1, "R1 field after reset", field, 1);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);

    // frame A: all four values back to back
    repeat (10) @(negedge clk);
    seg_q.delete();
    send_sym(2'b00, 1'b0, 1'b0);
    send_sym(2'b01, 1'b0, 1'b0);
    send_sym(2'b10, 1'b0, 1'b0);
    send_sym(2'b11, 1'b1, 1'b0);
    wait_idle();
    chk(seg_q.size() == 12, "R5 segment count frame A", seg_q.size(), 12);
    if (seg_q.size() == 12) begin
      chk(seg_q[1] == 248, "R2 lead gap", seg_q[1], 248);
      chk(seg_q[2] == 144, "R3 reference pulse", seg_q[2], 144);
      for (int k = 3; k <= 11; k += 2)
        chk(seg_q[k] == 160, "R5 off gap", seg_q[k], 160);
      for (int k = 0; k < 4; k++)
        chk(seg_q[4 + 2 * k] == (18 + 16 * k) * 8, "R4 symbol width", seg_q[4 + 2 * k], (18 + 16 * k) * 8);
    end

    // frame B: single symbol 11, ticks stalled mid-pulse
    seg_q.delete();
    send_sym(2'b11, 1'b1, 1'b0);
    while (m_phase != 4) @(negedge clk);
    repeat (50) @(negedge clk);
    tick_en = 1'b0;
    #1;
    begin
      bit f0;
      f0 = field;
      repeat (200) begin
        @(negedge clk);
        data = 2'($urandom);
      end
      #1;
      chk(field == f0 && field == 1'b1, "R9 frozen without tick", field, f0);
    end
    tick_en = 1'b1;
    wait_idle();
    chk(seg_q.size() == 6, "R3 segment count frame B", seg_q.size(), 6);
    if (seg_q.size() == 6) begin
      chk(seg_q[2] == 144, "R3 reference ignores first value", seg_q[2], 144);
      chk(seg_q[4] == 528, "R4 R6 width of 11 with scrambled data", seg_q[4], 528);
      chk(seg_q[5] == 160, "R5 final gap", seg_q[5], 160);
    end

    // frame C: mixed values, some starved gaps
    send_sym(2'b10, 1'b0, 1'b0);
    send_sym(2'b01, 1'b0, 1'b1);
    send_sym(2'b11, 1'b0, 1'b0);
    send_sym(2'b00, 1'b0, 1'b1);
    send_sym(2'b10, 1'b1, 1'b1);
    wait_idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired phase=%0d expected=idle", m_phase);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule